// File: doc/BRIEF.md
# Microcode Fetch Stage with Static Branch Prediction

This block is the front half of a two-stage microcoded engine. It keeps a speculative fetch PC and a synchronous microcode store. Each store entry holds a 32-bit instruction and two tag bits: a branch bit and a predict-taken bit. From the tag bits of the instruction it has just read, the stage picks the next address without decoding the instruction. The next address is either the following word or a target taken from a fixed low field of the instruction. The fetched word goes to the execute stage together with its PC and a valid bit.

Execute can send back two requests. A redirect carries a resolved target: the wrong-path word is killed in the same cycle and the target word arrives on the next cycle. A stall makes the stage read its current PC again instead of advancing. The store is filled through a plain write port, and only while the engine is held in load mode. Fetch stays idle during load mode and starts again from address 0 once load mode is released.

Top module: `ucode_fetch`

## Requirements
- R1: When reset is released with load mode low, instrValid is 0 in the first cycle. The word at address 0 is presented with instrValid 1 one clock edge later.
- R2: A store entry is 34 bits: bit 33 is the branch bit, bit 32 is the predict-taken bit and bits 31:0 are the instruction. The presented instrWord, instrBranch and instrPredTaken are the fields of the entry at instrPc.
- R3: If the presented valid word does not have both tag bits set, and there is no redirect, stall or load mode, the next presented PC is instrPc+1, wrapping modulo the store depth.
- R4: If the presented valid word has both tag bits set, and there is no redirect, stall or load mode, the next presented PC is instrWord[TGT_LSB +: ADDR_W].
- R5: In any cycle with exRedirect high, instrValid is 0. On the next cycle the word at exTarget is presented with instrValid 1, so the penalty is one cycle.
- R6: With exStall high and no redirect, the next cycle presents the same PC and the same word again.
- R7: When exRedirect and exStall are both high, the redirect is carried out and the stall has no effect.
- R8: A write request made while load mode is low leaves the store unchanged. Writes made during load mode land at wrAddr.
- R9: While load mode is high, instrValid is 0 and redirect and stall are ignored. After release, fetch restarts at address 0 as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadMode | input | 1 | Holds the engine in load mode and enables store writes |
| wrEn | input | 1 | Store write request |
| wrAddr | input | ADDR_W | Store write address |
| wrInstr | input | INSTR_W | Instruction to write |
| wrBranch | input | 1 | Branch tag to write |
| wrPredTaken | input | 1 | Predict-taken tag to write |
| exRedirect | input | 1 | Mispredict redirect from execute |
| exTarget | input | ADDR_W | Resolved target for the redirect |
| exStall | input | 1 | Stall request from execute |
| instrValid | output | 1 | Presented word is valid |
| instrWord | output | INSTR_W | Presented instruction |
| instrPc | output | ADDR_W | PC of the presented instruction |
| instrBranch | output | 1 | Branch tag of the presented word |
| instrPredTaken | output | 1 | Predict-taken tag of the presented word |

## Verification
The assertions check on every cycle that each next-address choice lands where it should. A redirect must land on its target, a predicted branch on the word's target field and a plain advance on the PC plus one. A stall must repeat the same PC and word, and a store write may only be strobed in load mode. Only the bench's scenarios can show the end-to-end results. These are the delivered word contents across a full sweep of the store, the killed valid bit in a redirect cycle, that writes made outside load mode are dropped, and the restart at address 0 after reset and after each load-mode release.

// File: rtl/ufetch_pkg.sv
package ufetch_pkg;

  // Number of tag bits stored beside each instruction.
  localparam int TAG_W = 2;

  // Next-address selection from control to datapath; exactly one select is set.
  typedef struct packed {
    logic writeRam;  // store write this cycle
    logic toZero;    // load mode: park at address 0
    logic redirect;  // take resolved target from execute
    logic refetch;   // read current PC again
    logic jump;      // predicted taken: use target field
    logic advance;   // sequential PC + 1
  } fetchStb_t;

endpackage

// File: rtl/ufetch_ctrl.sv
module ufetch_ctrl
  import ufetch_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      loadMode,
  input  logic      wrEn,
  input  logic      exRedirect,
  input  logic      exStall,
  input  logic      predTaken,
  output fetchStb_t stb,
  output logic      validQ,
  output logic      validOut
);

  always_comb begin
    stb          = '0;
    stb.writeRam = loadMode & wrEn;
    if (loadMode)                 stb.toZero   = 1'b1;
    else if (exRedirect)          stb.redirect = 1'b1;
    else if (exStall || !validQ)  stb.refetch  = 1'b1;
    else if (predTaken)           stb.jump     = 1'b1;
    else                          stb.advance  = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= !loadMode;
  end

  // A wrong-path word is killed in the cycle the redirect arrives.
  assign validOut = validQ & ~exRedirect & ~loadMode;

  // R9: load mode leaves no valid word behind on the next cycle.
  a_r9_load_idles: assert property (@(posedge clk) disable iff (!rstN)
    loadMode |=> !validQ);

  // R7: exactly one next-address select every cycle.
  a_r7_one_select: assert property (@(posedge clk) disable iff (!rstN)
    $countones({stb.toZero, stb.redirect, stb.refetch, stb.jump, stb.advance}) == 1);

endmodule

// File: rtl/ufetch_dpath.sv
module ufetch_dpath
  import ufetch_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int INSTR_W = 32,
  parameter int TGT_LSB = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadMode,
  input  fetchStb_t          stb,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [INSTR_W-1:0] wrInstr,
  input  logic               wrBranch,
  input  logic               wrPredTaken,
  input  logic [ADDR_W-1:0]  exTarget,
  output logic               predTaken,
  output logic [ADDR_W-1:0]  pcQ,
  output logic [INSTR_W-1:0] wordOut,
  output logic               branchOut,
  output logic               predOut
);

  localparam int DEPTH   = 1 << ADDR_W;
  localparam int ENTRY_W = INSTR_W + TAG_W;

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [ENTRY_W-1:0] ramQ;
  logic [ADDR_W-1:0]  rdAddr;
  logic [ADDR_W-1:0]  tgtField;

  assign tgtField  = ramQ[TGT_LSB +: ADDR_W];
  assign wordOut   = ramQ[INSTR_W-1:0];
  assign branchOut = ramQ[INSTR_W+1];
  assign predOut   = ramQ[INSTR_W];
  assign predTaken = branchOut & predOut;

  always_comb begin
    rdAddr = pcQ + ADDR_W'(1);
    if (stb.toZero)        rdAddr = '0;
    else if (stb.redirect) rdAddr = exTarget;
    else if (stb.refetch)  rdAddr = pcQ;
    else if (stb.jump)     rdAddr = tgtField;
  end

  // Synchronous store: write and registered read.
  always_ff @(posedge clk) begin
    if (stb.writeRam) mem[wrAddr] <= {wrBranch, wrPredTaken, wrInstr};
    ramQ <= mem[rdAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pcQ <= '0;
    else       pcQ <= rdAddr;
  end

  // R8: the store is only written in load mode.
  a_r8_write_in_load: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeRam |-> loadMode);

  // R5: a redirect lands on the resolved target.
  a_r5_redirect_lands: assert property (@(posedge clk) disable iff (!rstN)
    stb.redirect |=> pcQ == $past(exTarget));

  // R4: a predicted-taken word steers fetch to its target field.
  a_r4_jump_lands: assert property (@(posedge clk) disable iff (!rstN)
    stb.jump |=> pcQ == $past(tgtField));

  // R3: sequential advance moves by one.
  a_r3_advance_by_one: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |=> pcQ == ADDR_W'($past(pcQ) + ADDR_W'(1)));

endmodule

// File: rtl/ucode_fetch.sv
module ucode_fetch
  import ufetch_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int INSTR_W = 32,
  parameter int TGT_LSB = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadMode,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [INSTR_W-1:0] wrInstr,
  input  logic               wrBranch,
  input  logic               wrPredTaken,
  input  logic               exRedirect,
  input  logic [ADDR_W-1:0]  exTarget,
  input  logic               exStall,
  output logic               instrValid,
  output logic [INSTR_W-1:0] instrWord,
  output logic [ADDR_W-1:0]  instrPc,
  output logic               instrBranch,
  output logic               instrPredTaken
);

  fetchStb_t stb;
  logic      predTaken;
  logic      validQ;

  ufetch_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .loadMode   (loadMode),
    .wrEn       (wrEn),
    .exRedirect (exRedirect),
    .exStall    (exStall),
    .predTaken  (predTaken),
    .stb        (stb),
    .validQ     (validQ),
    .validOut   (instrValid)
  );

  ufetch_dpath #(
    .ADDR_W  (ADDR_W),
    .INSTR_W (INSTR_W),
    .TGT_LSB (TGT_LSB)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .loadMode    (loadMode),
    .stb         (stb),
    .wrAddr      (wrAddr),
    .wrInstr     (wrInstr),
    .wrBranch    (wrBranch),
    .wrPredTaken (wrPredTaken),
    .exTarget    (exTarget),
    .predTaken   (predTaken),
    .pcQ         (instrPc),
    .wordOut     (instrWord),
    .branchOut   (instrBranch),
    .predOut     (instrPredTaken)
  );

  // R6: a stall on a valid word repeats the same PC and word.
  a_r6_stall_repeats: assert property (@(posedge clk) disable iff (!rstN)
    (exStall && !exRedirect && !loadMode && validQ)
      |=> (instrPc == $past(instrPc)) && (instrWord == $past(instrWord)));

endmodule

// File: tb/ucode_fetch_tb_top.sv
module ucode_fetch_tb_top;

  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          loadMode = 1'b1;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [31:0]   wrInstr = '0;
  logic          wrBranch = 1'b0;
  logic          wrPredTaken = 1'b0;
  logic          exRedirect = 1'b0;
  logic [AW-1:0] exTarget = '0;
  logic          exStall = 1'b0;
  logic          instrValid;
  logic [31:0]   instrWord;
  logic [AW-1:0] instrPc;
  logic          instrBranch;
  logic          instrPredTaken;

  ucode_fetch #(.ADDR_W(AW), .INSTR_W(32), .TGT_LSB(0)) dut_i (
    .clk(clk), .rstN(rstN), .loadMode(loadMode), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrInstr(wrInstr), .wrBranch(wrBranch), .wrPredTaken(wrPredTaken),
    .exRedirect(exRedirect), .exTarget(exTarget), .exStall(exStall),
    .instrValid(instrValid), .instrWord(instrWord), .instrPc(instrPc),
    .instrBranch(instrBranch), .instrPredTaken(instrPredTaken)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nErrors = 0;
  logic [33:0] memM [DEPTH];
  int pcM = 0;
  logic validM = 1'b0;
  string reason = "R1";
  int unsigned seed = 32'h1234_5678;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp, string what);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [33:0] mkWord(int a, int s);
    logic [15:0] hi;
    logic [9:0]  mid;
    logic [5:0]  tgt;
    hi  = 16'((a * 40503 + s * 977) & 16'hffff);
    mid = 10'((a ^ s) & 10'h3ff);
    tgt = 6'((a * 7 + 3 + s) % DEPTH);
    return {((a + s) % 3 == 0), (a % 2 == 0), hi, mid, tgt};
  endfunction

  function automatic int unsigned nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  // One cycle: drive at the falling edge, check, clock, update the model.
  task automatic cyc(logic ld, logic we, int wa, logic [33:0] wd, logic rd, int tg, logic st);
    logic [33:0] w;
    loadMode = ld; wrEn = we; wrAddr = AW'(wa);
    {wrBranch, wrPredTaken, wrInstr} = wd;
    exRedirect = rd; exTarget = AW'(tg); exStall = st;
    #1;
    chk(ld ? "R9" : (rd ? "R5" : reason), 64'(instrValid), 64'(validM && !rd && !ld), "instrValid");
    if (validM && !ld) begin
      chk(reason, 64'(instrPc), 64'(pcM), "instrPc");
      chk("R2", 64'(instrWord), 64'(memM[pcM][31:0]), "instrWord");
      chk("R2", 64'({instrBranch, instrPredTaken}), 64'(memM[pcM][33:32]), "tag bits");
    end
    @(posedge clk);
    if (ld) begin
      if (we) memM[wa] = wd;
      pcM = 0; validM = 1'b0; reason = "R9";
    end else if (rd) begin
      pcM = tg; validM = 1'b1; reason = st ? "R7" : "R5";
    end else if (st || !validM) begin
      reason = st && validM ? "R6" : "R1"; validM = 1'b1;
    end else begin
      w = memM[pcM];
      if (w[33] && w[32]) begin pcM = int'(w[5:0]); reason = "R4"; end
      else begin pcM = (pcM + 1) % DEPTH; reason = "R3"; end
    end
    @(negedge clk);
  endtask

  task automatic loadAll(int s);
    for (int a = 0; a < DEPTH; a++) cyc(1'b1, 1'b1, a, mkWord(a, s), 1'b0, 0, 1'b0);
  endtask

  initial begin
    #(200000 * 10);
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    @(negedge clk);
    #1 chk("R1", 64'(instrValid), 64'(0), "valid in reset");
    @(negedge clk);
    rstN = 1'b1;
    // R9: load with redirect and stall asserted, which must be ignored.
    cyc(1'b1, 1'b1, 0, mkWord(0, 1), 1'b1, 9, 1'b1);
    loadAll(1);
    // R1/R9: first cycle after release is invalid, then address 0.
    for (int i = 0; i < 300; i++) cyc(1'b0, 1'b0, 0, '0, 1'b0, 0, 1'b0);
    // R3/R4 from every start address via redirects.
    for (int a = 0; a < DEPTH; a++) begin
      cyc(1'b0, 1'b0, 0, '0, 1'b1, a, 1'b0);
      for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0, 0, '0, 1'b0, 0, 1'b0);
    end
    // Mixed redirect / stall traffic, including both at once (R7).
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      r = nextRand();
      cyc(1'b0, 1'b0, 0, '0, (r % 8) == 0, int'((r >> 4) % DEPTH), ((r >> 12) % 4) == 0);
    end
    // R8: writes outside load mode must be dropped.
    for (int a = 0; a < 8; a++) cyc(1'b0, 1'b1, a, ~mkWord(a, 1), 1'b0, 0, 1'b0);
    for (int a = 0; a < 8; a++) begin
      cyc(1'b0, 1'b0, 0, '0, 1'b1, a, 1'b0);
      #1 chk("R8", 64'(instrWord), 64'(memM[a][31:0]), "word after ignored write");
      cyc(1'b0, 1'b0, 0, '0, 1'b0, 0, 1'b1);
    end
    // R9: reload mid-run with new content, then restart at 0.
    loadAll(7);
    for (int i = 0; i < 1500; i++) begin
      int unsigned r;
      r = nextRand();
      cyc(1'b0, 1'b0, 0, '0, (r % 11) == 0, int'((r >> 4) % DEPTH), ((r >> 12) % 5) == 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule